// File: doc/BRIEF.md
# Four-channel PWM controller

The block generates four independent pulse-width modulated outputs. Software sets each one through a single 32-bit control word on a simple write-strobe bus. The word holds an enable flag, an 8-bit duty count and a 13-bit clock divider. An enabled channel divides the input clock by the divider setting plus one. It then counts frames of 256 divided ticks and drives its output high for the first `duty` ticks of every frame.

The block is used by writing the duty and divider fields, then setting the enable flag. Software may do both in one write, or write the fields while the channel is off and set the flag later with a read-modify-write. Changes made to a running channel wait for the end of the current frame, so no partial or glitched pulse is produced. Writing zero stops a channel at once: its output drops low and its counters clear, so the next enable starts a fresh frame. Reads are combinational and return the stored word of the addressed channel.

Top module: `pwm_quad`

## Requirements
- R1: After reset every control word reads 0 and all four outputs are low.
- R2: Channel n (n = 0..3) is at byte offset 16·n. In the word, bit 31 is the enable, bits 23:16 the duty and bits 12:0 the divider field. A read at that offset returns the stored fields, and bits 30:24 and 15:13 always read as 0.
- R3: An access to any other offset (low four address bits not zero, or offset above 0x3F) reads 0, and a write there changes no channel word and no output.
- R4: An enabled channel with divider field p and duty d repeats a frame of 256·(p+1) clocks. Its output is high for the first d·(p+1) clocks of each frame and low for the rest. The first frame starts with the output value seen right after the second rising edge following the enabling write edge.
- R5: A duty of 0 gives an output that is always low. A duty of 255 gives high for 255·(p+1) clocks and low for the last p+1 clocks of every frame.
- R6: Fields written while the enable bit is clear leave the output low. A later read-modify-write that sets bit 31 starts the channel with those fields.
- R7: Clearing bit 31 (for example by writing 0) forces the output low from the second edge after the write, whatever point the frame had reached. A later enable starts a new frame from its beginning.
- R8: A write to a running channel that keeps bit 31 set takes effect at the first frame boundary after the write edge. The current frame finishes with the old duty and divider.
- R9: Writing one channel does not disturb the waveform of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W (8) | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | NCH (4) | PWM outputs, one bit per channel |

## Verification
A divider counter that runs one tick too long or too short makes every later high phase and frame boundary drift. The drift shows at the output within one frame and grows each frame after that, so the bench compares each output against an arithmetic model on every clock. A shadow copy of duty or divider loaded at the wrong time shows as a wrong pulse width in the frame that follows an update written while the channel runs. Counters left uncleared on disable show as a first pulse of the wrong length right after re-enable. A decode fault shows as a readback mismatch, or as a change on a neighbouring channel after the bad write, within one to two clocks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int WORD_W  = 32;
  localparam int DUTY_W  = 8;
  localparam int PRE_W   = 13;
  localparam int EN_BIT  = 31;
  localparam int DUTY_LSB = 16;
  localparam int STRIDE_LSB = 4;  // 16-byte register stride

  typedef struct packed {
    logic              en;
    logic [DUTY_W-1:0] duty;
    logic [PRE_W-1:0]  presc;
  } cfg_t;

  function automatic logic [WORD_W-1:0] to_word(cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT] = c.en;
    w[DUTY_LSB +: DUTY_W] = c.duty;
    w[PRE_W-1:0] = c.presc;
    return w;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output cfg_t [NCH-1:0]     cfg_o
);
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HI_LSB = STRIDE_LSB + CH_W;

  logic [CH_W-1:0] sel_idx;
  logic            low_ok, high_ok, hit;
  cfg_t            wr_cfg;
  logic            unused_wbits;

  assign sel_idx = addr_i[STRIDE_LSB +: CH_W];
  assign low_ok  = (addr_i[STRIDE_LSB-1:0] == '0);

  if (ADDR_W > HI_LSB) begin : g_hi
    assign high_ok = (addr_i[ADDR_W-1:HI_LSB] == '0);
  end else begin : g_nohi
    assign high_ok = 1'b1;
  end

  assign hit = low_ok && high_ok && (int'(sel_idx) < NCH);

  assign wr_cfg.en    = wdata_i[EN_BIT];
  assign wr_cfg.duty  = wdata_i[DUTY_LSB +: DUTY_W];
  assign wr_cfg.presc = wdata_i[PRE_W-1:0];
  assign unused_wbits = ^{wdata_i[EN_BIT-1:DUTY_LSB+DUTY_W], wdata_i[DUTY_LSB-1:PRE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (wr_en_i && hit) begin
      for (int k = 0; k < NCH; k++) begin
        if (int'(sel_idx) == k) cfg_o[k] <= wr_cfg;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCH; k++) begin
      if (hit && int'(sel_idx) == k) rdata_o = to_word(cfg_o[k]);
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output logic pwm_o
);
  logic              run_q;
  logic [DUTY_W-1:0] act_duty, tick_q;
  logic [PRE_W-1:0]  act_presc, div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      act_duty  <= '0;
      act_presc <= '0;
      div_q     <= '0;
      tick_q    <= '0;
    end else begin
      run_q <= cfg_i.en;
      if (!run_q) begin
        // idle: counters parked, shadow tracks the register
        div_q     <= '0;
        tick_q    <= '0;
        act_duty  <= cfg_i.duty;
        act_presc <= cfg_i.presc;
      end else if (div_q == act_presc) begin
        div_q  <= '0;
        tick_q <= tick_q + 1'b1;
        if (tick_q == '1) begin
          act_duty  <= cfg_i.duty;
          act_presc <= cfg_i.presc;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign pwm_o = run_q && (tick_q < act_duty);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [NCH-1:0]      pwm_o
);
  cfg_t [NCH-1:0] cfg_q;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_chan i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg_q[g]),
      .pwm_o  (pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
  import pwm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [WORD_W-1:0]  wdata_i,
  input logic [WORD_W-1:0]  rdata_i,
  input cfg_t [NCH-1:0]     cfg_i,
  input logic [NCH-1:0]     pwm_i
);
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int HI_LSB = STRIDE_LSB + CH_W;
  localparam logic [WORD_W-1:0] ZERO_MASK = 32'h7F00_E000;

  logic            in_map, hi_zero;
  logic [CH_W-1:0] idx;
  logic            lw_v;
  logic [CH_W-1:0] lw_idx;
  cfg_t            lw_cfg;
  logic            unused_chk;

  assign idx = addr_i[STRIDE_LSB +: CH_W];
  if (ADDR_W > HI_LSB) begin : g_hi
    assign hi_zero = ~|addr_i[ADDR_W-1:HI_LSB];
  end else begin : g_nohi
    assign hi_zero = 1'b1;
  end
  assign in_map = hi_zero && ~|addr_i[STRIDE_LSB-1:0] && (int'(idx) < NCH);
  assign unused_chk = ^{wdata_i[EN_BIT-1:DUTY_LSB+DUTY_W], wdata_i[DUTY_LSB-1:PRE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_v   <= 1'b0;
      lw_idx <= '0;
      lw_cfg <= '0;
    end else begin
      lw_v   <= wr_en_i && in_map;
      lw_idx <= idx;
      lw_cfg <= '{en: wdata_i[EN_BIT], duty: wdata_i[DUTY_LSB +: DUTY_W], presc: wdata_i[PRE_W-1:0]};
    end
  end

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i & ZERO_MASK) == '0);

  assert_write_stored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lw_v |-> (cfg_i[lw_idx] == lw_cfg));

  assert_oob_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_map |-> (rdata_i == '0));

  assert_oob_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_map) |=> $stable(cfg_i));

  for (genvar g = 0; g < NCH; g++) begin : g_off
    assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cfg_i[g].en) |-> !pwm_i[g]);
  end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) i_pwm_quad_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_i (rdata_o),
  .cfg_i   (cfg_q),
  .pwm_i   (pwm_o)
);

// File: tb/test_pwm_quad.sv
module test_pwm_quad;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // bench model of each channel
  bit m_en [NCH];
  int m_start [NCH], m_stop [NCH], m_duty [NCH], m_p [NCH];
  bit pend_v [NCH];
  int pend_w [NCH], pend_duty [NCH], pend_p [NCH];
  int mism [NCH], snap [NCH];

  pwm_quad i_pwm_quad (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .pwm_o (pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin
      m_en[ch] = 0; m_start[ch] = 0; m_stop[ch] = 0; m_duty[ch] = 0; m_p[ch] = 0;
      pend_v[ch] = 0; pend_w[ch] = 0; pend_duty[ch] = 0; pend_p[ch] = 0;
      mism[ch] = 0; snap[ch] = 0;
    end
  end

  always @(negedge clk) begin
    int c, len;
    bit running, exp_v;
    if (rst_n) begin
      for (int ch = 0; ch < NCH; ch++) begin
        running = m_en[ch] ? (cyc >= m_start[ch]) : (cyc < m_stop[ch]);
        exp_v = 1'b0;
        if (running) begin
          c = cyc - m_start[ch];
          len = 256 * (m_p[ch] + 1);
          if (c == len) begin
            m_start[ch] = cyc;
            c = 0;
            if (pend_v[ch] && pend_w[ch] < cyc) begin
              m_duty[ch] = pend_duty[ch];
              m_p[ch] = pend_p[ch];
              pend_v[ch] = 0;
            end
          end
          exp_v = (c / (m_p[ch] + 1)) < m_duty[ch];
        end
        if (pwm[ch] !== exp_v) mism[ch]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [31:0] mk(bit en, int duty, int p);
    return {en, 7'b0, duty[7:0], 3'b0, p[12:0]};
  endfunction

  function automatic int rev8(int v);
    logic [7:0] a, b;
    a = v[7:0];
    for (int i = 0; i < 8; i++) b[i] = a[7-i];
    return int'(b);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int w, ch;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    w = cyc + 1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a[3:0] == 4'h0 && a[7:6] == 2'b00) begin
      ch = int'(a[5:4]);
      if (d[31] && !m_en[ch]) begin
        m_en[ch] = 1; m_start[ch] = w + 1;
        m_duty[ch] = int'(d[23:16]); m_p[ch] = int'(d[12:0]); pend_v[ch] = 0;
      end else if (d[31]) begin
        pend_v[ch] = 1; pend_w[ch] = w;
        pend_duty[ch] = int'(d[23:16]); pend_p[ch] = int'(d[12:0]);
      end else if (m_en[ch]) begin
        m_en[ch] = 0; m_stop[ch] = w + 1; pend_v[ch] = 0;
      end
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic win(input int n, input string req);
    @(posedge clk);
    #1;
    for (int ch = 0; ch < NCH; ch++) snap[ch] = mism[ch];
    repeat (n) @(posedge clk);
    #1;
    for (int ch = 0; ch < NCH; ch++)
      chk(mism[ch] == snap[ch], req, mism[ch] - snap[ch], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int tot;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++) begin
      rd(8'(ch * 16), v);
      chk(v == 32'h0, "R1 word", v, 0);
    end
    chk(pwm == 4'h0, "R1 pwm", pwm, 0);

    // R2 field layout and zero bits
    wr(8'h10, 32'h7FFF_FFFF);
    rd(8'h10, v);
    chk(v == 32'h00FF_1FFF, "R2 ch1", v, 32'h00FF_1FFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v);
    chk(v == 32'h80FF_1FFF, "R2 ch2", v, 32'h80FF_1FFF);
    win(20, "R5 max duty start");
    wr(8'h20, 32'h0);
    rd(8'h20, v);
    chk(v == 32'h0, "R7 zero word", v, 0);

    // R3 off-map accesses
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'h04, v); chk(v == 0, "R3 read 04", v, 0);
    rd(8'h40, v); chk(v == 0, "R3 read 40", v, 0);
    rd(8'h18, v); chk(v == 0, "R3 read 18", v, 0);
    rd(8'hC0, v); chk(v == 0, "R3 read C0", v, 0);
    rd(8'h00, v); chk(v == 0, "R3 ch0 kept", v, 0);
    rd(8'h10, v); chk(v == 32'h00FF_1FFF, "R3 ch1 kept", v, 32'h00FF_1FFF);
    rd(8'h30, v); chk(v == 0, "R3 ch3 kept", v, 0);
    win(300, "R3 outputs");

    // R6 configure while off, then read-modify-write enable
    wr(8'h00, mk(0, 64, 3));
    win(1500, "R6 held low");
    rd(8'h00, v);
    chk(v == mk(0, 64, 3), "R6 readback", v, mk(0, 64, 3));
    wr(8'h00, v | 32'h8000_0000);
    win(2100, "R6 started");

    // R4 several dividers at once
    wr(8'h10, mk(1, 128, 2));
    wr(8'h20, mk(1, 255, 7));
    wr(8'h30, mk(1, 1, 1));
    win(4200, "R4 dividers");

    // R8 updates while running
    wr(8'h00, mk(1, 10, 1));
    win(300, "R8 old frame");
    wr(8'h10, mk(1, 3, 0));
    win(3072, "R8 new frame");

    // R7 stop mid frame and restart fresh
    wr(8'h20, 32'h0);
    win(600, "R7 stopped");
    wr(8'h20, mk(1, 100, 0));
    win(600, "R7 restart");

    // R9 reconfigure ch3 while others run
    wr(8'h30, 32'h0);
    wr(8'h30, mk(1, 200, 3));
    win(2100, "R9 others intact");

    // R4/R5 exhaustive duty sweep
    for (int d = 0; d < 256; d++) begin
      for (int ch = 0; ch < NCH; ch++) wr(8'(ch * 16), 32'h0);
      wr(8'h00, mk(1, d, 0));
      wr(8'h10, mk(1, 255 - d, 0));
      wr(8'h20, mk(1, d ^ 8'h5A, 0));
      wr(8'h30, mk(1, rev8(d), 0));
      win(262, (d == 0 || d == 255) ? "R5 sweep edge" : "R4 sweep");
    end

    @(posedge clk);
    #1;
    tot = 0;
    for (int ch = 0; ch < NCH; ch++) tot += mism[ch];
    chk(tot == 0, "R4 all cycles", tot, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule